// File: doc/BRIEF.md
# Way-Halting Four-Way Cache Lookup

This block is the lookup and fill path of a four-way set-associative cache that saves read energy by stopping ways early. Next to the full tag and data arrays it keeps a small side store with the lowest four tag bits and the valid bit of every way in every set. When a request arrives, those four bits are compared against the request's low tag bits in the same cycle that the set index is decoded. A way whose low bits differ, or which holds no valid line, is halted: its tag and data arrays receive no read enable. Only the surviving ways are read and given a full tag compare.

A request is taken in one cycle and answered in the next, so a halted access costs no extra cycle compared with a plain four-way cache. A miss is not serviced by the block itself. The surrounding logic supplies the line through the refill port. The refill writes the full tag, halt bits, valid bit and data of a victim way in one cycle. The victim is chosen per set by tree pseudo-LRU.

The control is a two-state machine. `ST_IDLE` means no response is due. `ST_RESP` means a response is presented this cycle. The machine moves from either state to `ST_RESP` on a cycle with `req_valid` high, and to `ST_IDLE` on a cycle with it low. The per-way read enables are brought out so that energy can be counted and halting can be observed.

Top module: `wh_cache_lookup`

## Requirements
- R1: The low IDX_W address bits select the set. The remaining upper bits form the tag. The halt bits are tag bits [3:0].
- R2: In the cycle a request is presented, `way_rd_en[w]` is 1 exactly when `req_valid` is 1, way w of the addressed set is valid, and its stored halt bits equal the request's halt bits. With `req_valid` low, all enables are 0.
- R3: `rsp_valid` is 1 in the cycle after each cycle with `req_valid` high, and 0 otherwise.
- R4: `rsp_hit` is 1 only when a way enabled for that request holds the full request tag. On a hit, `rsp_way` gives that way and `rsp_data` gives its data.
- R5: If no way is enabled, the response is a miss. On any miss, `rsp_way` is 0 and `rsp_data` is 0.
- R6: A hit needs the valid bit, the halt-bit match and the full tag match together. A way whose halt bits match but whose upper tag bits differ gives a miss.
- R7: A refill writes the tag, halt bits, valid bit and data of one victim way in a single cycle. A lookup of that address in any later cycle hits with the refilled data.
- R8: Each set holds three PLRU bits b0, b1 and b2, reset to 0. The victim is way b1 when b0=0, and way 2+b2 when b0=1. From reset, successive fills of one set therefore land in ways 0, 2, 1, 3.
- R9: Touching way w sets the bits as follows. For w<2: b0=1 and b1=!w[0]. For w>=2: b0=0 and b2=!w[0]. A hit touches its set in its response cycle, and a refill touches the victim. When both touch the same set in one cycle, the refill's victim is chosen after the hit's update.
- R10: Reset clears every valid bit, so after reset every lookup enables no way and misses.
- R11: A lookup in the same cycle as a refill of the same set sees the contents from before the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Lookup address |
| refill_valid | input | 1 | Refill write strobe |
| refill_addr | input | ADDR_W | Address of the line being filled |
| refill_data | input | DATA_W | Data of the line being filled |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Response is a hit |
| rsp_way | output | 2 | Hitting way, 0 on miss |
| rsp_data | output | DATA_W | Hit data, 0 on miss |
| way_rd_en | output | 4 | Per-way tag and data array read enable |

## Verification
A lookup and a refill can fall in the same cycle. The same cycle can also carry a hit's PLRU update and a refill's victim choice for one set. The bench provokes both by driving random lookups and refills together on only two sets, with a small tag pool, so that halt-bit aliasing and same-set collisions are frequent. Directed cases add a same-address refill-plus-lookup and a hit followed at once by a refill. A reference model checks the outcome. It applies the pending hit update, then evaluates the lookup on the old contents, then applies the refill. The model is judged through the enables, the hit flag and the way and data returned by later lookups.

// File: rtl/wh_pkg.sv
package wh_pkg;
    localparam int WAYS   = 4;
    localparam int HALT_W = 4;
    localparam int WAY_W  = $clog2(WAYS);

    typedef logic [2:0]       plru_t;
    typedef logic [WAY_W-1:0] way_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } lk_state_t;

    function automatic way_t plru_victim(plru_t p);
        if (!p[0]) return p[1] ? way_t'(1) : way_t'(0);
        else       return p[2] ? way_t'(3) : way_t'(2);
    endfunction

    function automatic plru_t plru_touch(plru_t p, way_t w);
        plru_t r;
        r = p;
        if (!w[1]) begin
            r[0] = 1'b1;
            r[1] = ~w[0];
        end else begin
            r[0] = 1'b0;
            r[2] = ~w[0];
        end
        return r;
    endfunction
endpackage

// File: rtl/wh_halt_store.sv
module wh_halt_store
    import wh_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [IDX_W-1:0]         lk_set,
    input  logic [HALT_W-1:0]        lk_halt,
    output logic [WAYS-1:0]          rd_en,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_set,
    input  way_t                     wr_way,
    input  logic [HALT_W-1:0]        wr_halt
);
    localparam int SETS = 1 << IDX_W;

    logic [HALT_W-1:0] halt_q [SETS][WAYS];
    logic [WAYS-1:0]   vld_q  [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (wr_en) begin
            vld_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) halt_q[wr_set][wr_way] <= wr_halt;
    end

    // Static compare, evaluated alongside set decode
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign rd_en[w] = lk_valid && vld_q[lk_set][w] &&
                          (halt_q[lk_set][w] == lk_halt);
    end
endmodule

// File: rtl/wh_way_bank.sv
module wh_way_bank #(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 13,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_set,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TAG_W-1:0]  tag_out,
    output logic [DATA_W-1:0] data_out
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [DATA_W-1:0] data_mem [SETS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_set]  <= wr_tag;
            data_mem[wr_set] <= wr_data;
        end
    end

    // Read port: array output only updates when enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_out  <= '0;
            data_out <= '0;
        end else if (rd_en) begin
            tag_out  <= tag_mem[rd_set];
            data_out <= data_mem[rd_set];
        end
    end
endmodule

// File: rtl/wh_plru_table.sv
module wh_plru_table
    import wh_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  way_t             touch_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_set,
    output way_t             victim
);
    localparam int SETS = 1 << IDX_W;

    plru_t plru_q [SETS];
    plru_t fill_view;

    always_comb begin
        fill_view = plru_q[fill_set];
        if (touch_en && touch_set == fill_set)
            fill_view = plru_touch(fill_view, touch_way);
        victim = plru_victim(fill_view);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) plru_q[s] <= '0;
        end else begin
            if (touch_en) plru_q[touch_set] <= plru_touch(plru_q[touch_set], touch_way);
            if (fill_en)  plru_q[fill_set]  <= plru_touch(fill_view, victim);
        end
    end
endmodule

// File: rtl/wh_cache_lookup.sv
module wh_cache_lookup
    import wh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              refill_valid,
    input  logic [ADDR_W-1:0] refill_addr,
    input  logic [DATA_W-1:0] refill_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_way,
    output logic [DATA_W-1:0] rsp_data,
    output logic [3:0]        way_rd_en
);
    localparam int TAG_W = ADDR_W - IDX_W;

    // Address split
    logic [IDX_W-1:0] req_set, fill_set;
    logic [TAG_W-1:0] req_tag, fill_tag;
    assign req_set  = req_addr[IDX_W-1:0];
    assign req_tag  = req_addr[ADDR_W-1:IDX_W];
    assign fill_set = refill_addr[IDX_W-1:0];
    assign fill_tag = refill_addr[ADDR_W-1:IDX_W];

    lk_state_t        state_q, state_d;
    logic [IDX_W-1:0] set_q;
    logic [TAG_W-1:0] tag_q;
    logic [WAYS-1:0]  en_q;

    logic [WAYS-1:0]   en;
    logic [TAG_W-1:0]  bank_tag  [WAYS];
    logic [DATA_W-1:0] bank_data [WAYS];
    logic [WAYS-1:0]   match;
    way_t              victim;
    way_t              hit_way;
    logic              hit;

    wh_halt_store #(.IDX_W(IDX_W)) u_halt (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_valid(req_valid),
        .lk_set  (req_set),
        .lk_halt (req_tag[HALT_W-1:0]),
        .rd_en   (en),
        .wr_en   (refill_valid),
        .wr_set  (fill_set),
        .wr_way  (victim),
        .wr_halt (fill_tag[HALT_W-1:0])
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        wh_way_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (en[w]),
            .rd_set  (req_set),
            .wr_en   (refill_valid && victim == way_t'(w)),
            .wr_set  (fill_set),
            .wr_tag  (fill_tag),
            .wr_data (refill_data),
            .tag_out (bank_tag[w]),
            .data_out(bank_data[w])
        );
        assign match[w] = en_q[w] && (bank_tag[w] == tag_q);
    end

    wh_plru_table #(.IDX_W(IDX_W)) u_plru (
        .clk      (clk),
        .rst_n    (rst_n),
        .touch_en (rsp_valid && hit),
        .touch_set(set_q),
        .touch_way(hit_way),
        .fill_en  (refill_valid),
        .fill_set (fill_set),
        .victim   (victim)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    // State register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            set_q   <= '0;
            tag_q   <= '0;
            en_q    <= '0;
        end else begin
            state_q <= state_d;
            en_q    <= en;
            if (req_valid) begin
                set_q <= req_set;
                tag_q <= req_tag;
            end
        end
    end

    // Outputs
    always_comb begin
        hit_way   = '0;
        hit       = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) begin
                hit_way = way_t'(w);
                hit     = 1'b1;
            end
        end
        unique case (state_q)
            ST_IDLE: rsp_valid = 1'b0;
            ST_RESP: begin
                rsp_valid = 1'b1;
                if (hit) rsp_data = bank_data[hit_way];
            end
        endcase
        rsp_hit   = rsp_valid && hit;
        rsp_way   = rsp_hit ? hit_way : 2'd0;
        way_rd_en = en;
    end
endmodule

// File: rtl/wh_cache_lookup_chk.sv
module wh_cache_lookup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic [3:0] way_rd_en,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic [1:0] rsp_way
);
    AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> way_rd_en == 4'b0000) else $error("idle enable"); // R2

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) else $error("missing response"); // R3

    AST_RSP_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid) else $error("spurious response"); // R3

    AST_HIT_WAY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ($past(way_rd_en) & (4'b0001 << rsp_way)) != 4'b0000)
        else $error("hit on a halted way"); // R4

    AST_ALL_HALTED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(way_rd_en) == 4'b0000) |-> !rsp_hit)
        else $error("hit with every way halted"); // R5

    AST_MISS_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_way == 2'd0) else $error("way on miss"); // R5
endmodule

bind wh_cache_lookup wh_cache_lookup_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .way_rd_en(way_rd_en),
    .rsp_valid(rsp_valid),
    .rsp_hit  (rsp_hit),
    .rsp_way  (rsp_way)
);

// File: tb/wh_cache_lookup_tb.sv
module wh_cache_lookup_tb;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 3;
    localparam int DATA_W = 32;
    localparam int SETS   = 1 << IDX_W;
    localparam int TAG_W  = ADDR_W - IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              refill_valid = 1'b0;
    logic [ADDR_W-1:0] refill_addr = '0;
    logic [DATA_W-1:0] refill_data = '0;
    logic              rsp_valid, rsp_hit;
    logic [1:0]        rsp_way;
    logic [DATA_W-1:0] rsp_data;
    logic [3:0]        way_rd_en;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wh_cache_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .refill_valid(refill_valid), .refill_addr(refill_addr), .refill_data(refill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_data(rsp_data), .way_rd_en(way_rd_en)
    );

    // Reference model state
    logic             m_vld  [SETS][4];
    logic [TAG_W-1:0] m_tag  [SETS][4];
    logic [DATA_W-1:0] m_data [SETS][4];
    logic [2:0]       m_plru [SETS];

    // Pending response expectation
    logic              p_req = 1'b0;
    logic              p_hit;
    logic [1:0]        p_way;
    logic [DATA_W-1:0] p_data;
    logic [IDX_W-1:0]  p_set;
    logic [3:0]        p_mask;
    string             p_tag;

    function automatic logic [1:0] f_victim(logic [2:0] p);
        if (!p[0]) return p[1] ? 2'd1 : 2'd0;
        return p[2] ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [2:0] f_touch(logic [2:0] p, logic [1:0] w);
        logic [2:0] r = p;
        if (w < 2) begin r[0] = 1'b1; r[1] = ~w[0]; end
        else       begin r[0] = 1'b0; r[2] = ~w[0]; end
        return r;
    endfunction

    // R1: set in the low bits, tag above, halt bits = tag[3:0]
    function automatic logic [ADDR_W-1:0] mk_addr(logic [TAG_W-1:0] t, logic [IDX_W-1:0] s);
        return {t, s};
    endfunction

    function automatic logic [3:0] f_mask(logic [ADDR_W-1:0] a);
        logic [3:0] m = '0;
        logic [IDX_W-1:0] s = a[IDX_W-1:0];
        logic [TAG_W-1:0] t = a[ADDR_W-1:IDX_W];
        for (int w = 0; w < 4; w++)
            m[w] = m_vld[s][w] && (m_tag[s][w][3:0] == t[3:0]);
        return m;
    endfunction

    function automatic logic f_present(logic [ADDR_W-1:0] a);
        for (int w = 0; w < 4; w++)
            if (m_vld[a[IDX_W-1:0]][w] && m_tag[a[IDX_W-1:0]][w] == a[ADDR_W-1:IDX_W]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(logic ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive a lookup and/or refill, check everything due
    task automatic step(logic rv, logic [ADDR_W-1:0] ra, logic fv,
                        logic [ADDR_W-1:0] fa, logic [DATA_W-1:0] fd, string tag);
        logic [3:0] em;
        logic [IDX_W-1:0] fs;
        logic [1:0] v;
        @(negedge clk);
        // response of previous cycle's request
        if (p_req) begin
            chk(rsp_valid === 1'b1, "R3", 64'(rsp_valid), 64'd1);
            chk(rsp_hit === p_hit, p_hit ? tag : (p_mask == 0 ? "R5" : "R6"), 64'(rsp_hit), 64'(p_hit));
            chk(rsp_way === p_way, p_hit ? "R8" : "R5", 64'(rsp_way), 64'(p_way));
            chk(rsp_data === p_data, p_hit ? "R7" : "R5", 64'(rsp_data), 64'(p_data));
            if (p_hit) m_plru[p_set] = f_touch(m_plru[p_set], p_way);
        end else begin
            chk(rsp_valid === 1'b0, "R3", 64'(rsp_valid), 64'd0);
        end
        req_valid = rv; req_addr = ra;
        refill_valid = fv; refill_addr = fa; refill_data = fd;
        #1;
        em = rv ? f_mask(ra) : 4'b0;
        chk(way_rd_en === em, "R2", 64'(way_rd_en), 64'(em));
        // R11: lookup sees contents before this cycle's refill
        p_req = rv; p_hit = 1'b0; p_way = 2'd0; p_data = '0;
        p_set = ra[IDX_W-1:0]; p_mask = em; p_tag = tag;
        for (int w = 0; w < 4; w++)
            if (em[w] && m_tag[p_set][w] == ra[ADDR_W-1:IDX_W]) begin
                p_hit = 1'b1; p_way = 2'(w); p_data = m_data[p_set][w];
            end
        if (fv) begin
            fs = fa[IDX_W-1:0];
            v = f_victim(m_plru[fs]);
            m_vld[fs][v] = 1'b1; m_tag[fs][v] = fa[ADDR_W-1:IDX_W]; m_data[fs][v] = fd;
            m_plru[fs] = f_touch(m_plru[fs], v);
        end
    endtask

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_plru[s] = '0;
            for (int w = 0; w < 4; w++) begin m_vld[s][w] = 0; m_tag[s][w] = '0; m_data[s][w] = '0; end
        end
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: after reset every lookup is halted and misses
        step(1, mk_addr(13'h0, 3'd0), 0, '0, '0, "R10");
        step(1, mk_addr(13'h1234, 3'd5), 0, '0, '0, "R10");
        chk(way_rd_en === 4'b0, "R10", 64'(way_rd_en), 64'd0);
        // R8: fills from reset land in ways 0,2,1,3
        for (int i = 0; i < 4; i++)
            step(0, '0, 1, mk_addr(13'(16'h10 * i + i), 3'd1), 32'hA0 + i, "R8");
        for (int i = 0; i < 4; i++)
            step(1, mk_addr(13'(16'h10 * i + i), 3'd1), 0, '0, '0, "R8");
        // R6: same halt bits, different upper tag: enabled yet miss
        step(1, mk_addr(13'h0F00 | 13'h2, 3'd1), 0, '0, '0, "R6");
        // R11: refill and lookup of the same line in one cycle
        step(1, mk_addr(13'h0777, 3'd2), 1, mk_addr(13'h0777, 3'd2), 32'hBEEF, "R11");
        step(1, mk_addr(13'h0777, 3'd2), 0, '0, '0, "R7");
        // R9: hit on way 0 followed at once by a refill of its set
        step(1, mk_addr(13'h0000, 3'd1), 0, '0, '0, "R9");
        step(0, '0, 1, mk_addr(13'h0555, 3'd1), 32'h5555, "R9");
        step(1, mk_addr(13'h0555, 3'd1), 0, '0, '0, "R9");
        // Random mix on two sets with a small tag pool
        for (int i = 0; i < 3000; i++) begin
            logic [TAG_W-1:0] t, ft;
            logic [IDX_W-1:0] s, fs;
            logic fv;
            t  = {9'($urandom % 3), 4'($urandom % 4)};
            s  = 3'($urandom % 2);
            ft = {9'($urandom % 3), 4'($urandom % 4)};
            fs = 3'($urandom % 2);
            fv = ($urandom % 3 == 0) && !f_present(mk_addr(ft, fs));
            step(($urandom % 4) != 0, mk_addr(t, s), fv, mk_addr(ft, fs), $urandom, "R4");
        end
        step(0, '0, 0, '0, '0, "R3");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule